// File: doc/BRIEF.md
# Five-Bit-Selected Integer ALU

This block is the purely combinational arithmetic and logic stage of a small RISC datapath. It accepts two operands and a 5-bit operation select code, and produces a result word together with a flag that is high whenever that result is all zeros.

One ripple chain of gate-level full adders performs addition, subtraction and signed comparison. Subtraction feeds the inverted second operand into the chain and forces the chain's carry-in to 1. The less-than decision comes from the sign of that difference, corrected by the overflow of the chain. Only six select codes do anything. Every other code returns zero.

Inside a datapath, the instruction decoder drives the select code, and a branch unit reads the zero flag to resolve an equality branch. The word width is a parameter with a default of 32.

Top module: `alu_core`

## Requirements
- R1: Select code 5'b00000 drives the result with the bitwise AND of opA and opB.
- R2: Select code 5'b00001 drives the result with the bitwise OR of opA and opB.
- R3: Select code 5'b01100 drives the result with the bitwise NOR of opA and opB.
- R4: Select code 5'b00010 drives the result with opA + opB modulo 2^WIDTH. A carry ripples through every bit position, so all-ones plus one gives zero.
- R5: Select code 5'b00110 drives the result with opA - opB modulo 2^WIDTH.
- R6: Select code 5'b00111 drives result bit 0 with 1 exactly when opA < opB as signed two's complement values, with all higher bits 0. The answer stays correct when opA - opB overflows.
- R7: Any select code other than the six listed above drives the result with zero, whatever the operands.
- R8: The zero output is 1 exactly when every bit of the result is 0, for every select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand; subtrahend for subtract and compare |
| opCode | input | 5 | Operation select code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
With a 4-bit copy of the block, the bench sweeps every select code against every operand pair. This covers signed compares across the overflow boundary, such as a most-negative value against a positive one. A design that takes less-than from the raw difference sign would flip those answers.

Directed 32-bit cases cover the following:
- A full carry ripple, which shows up a broken carry link as a wrong upper half.
- Subtraction with equal operands, which catches a missing carry-in of 1 because the result would be all ones instead of zero.
- Unlisted select codes, where a decoder that aliases on partial bits would leak a live result and clear the zero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [4:0] OP_AND = 5'b00000;
  localparam logic [4:0] OP_OR  = 5'b00001;
  localparam logic [4:0] OP_ADD = 5'b00010;
  localparam logic [4:0] OP_SUB = 5'b00110;
  localparam logic [4:0] OP_SLT = 5'b00111;
  localparam logic [4:0] OP_NOR = 5'b01100;

  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selNor;
    logic selSum;
    logic selSlt;
    logic invertB;
  } aluCtrl_t;
endpackage

// File: rtl/alu_fulladd.sv
module alu_fulladd (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic halfSum;
  assign halfSum = a ^ b;
  assign sum     = halfSum ^ cin;
  assign cout    = (a & b) | (cin & halfSum);
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [4:0] opCode,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    case (opCode)
      OP_AND: ctrl.selAnd = 1'b1;
      OP_OR:  ctrl.selOr  = 1'b1;
      OP_NOR: ctrl.selNor = 1'b1;
      OP_ADD: ctrl.selSum = 1'b1;
      OP_SUB: begin
        ctrl.selSum  = 1'b1;
        ctrl.invertB = 1'b1;
      end
      OP_SLT: begin
        ctrl.selSlt  = 1'b1;
        ctrl.invertB = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  // at most one source may drive the result
  always_comb begin
    AST_ONE_SOURCE: assert ($onehot0({ctrl.selAnd, ctrl.selOr, ctrl.selNor, ctrl.selSum, ctrl.selSlt})); // R7
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bFeed;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH:0]   carry;
  logic             overflow;
  logic             lessThan;

  assign bFeed    = ctrl.invertB ? ~opB : opB;
  assign carry[0] = ctrl.invertB;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ripple
    alu_fulladd fa_i (
      .a   (opA[i]),
      .b   (bFeed[i]),
      .cin (carry[i]),
      .sum (sumVec[i]),
      .cout(carry[i+1])
    );
  end

  assign overflow = carry[WIDTH] ^ carry[MSB];
  assign lessThan = sumVec[MSB] ^ overflow;

  always_comb begin
    result = ({WIDTH{ctrl.selAnd}} & (opA & opB))
           | ({WIDTH{ctrl.selOr}}  & (opA | opB))
           | ({WIDTH{ctrl.selNor}} & ~(opA | opB))
           | ({WIDTH{ctrl.selSum}} & sumVec)
           | ({WIDTH{ctrl.selSlt}} & {{MSB{1'b0}}, lessThan});
  end

  always_comb begin
    if (ctrl.selSum && !ctrl.invertB && opB == '0)
      AST_ADD_IDENTITY: assert (result == opA); // R4
    if (ctrl.invertB && opA == opB)
      AST_SUB_SELF: assert (sumVec == '0 && carry[WIDTH]); // R5
    if (ctrl.selSlt)
      AST_SLT_UPPER: assert (result[MSB:1] == '0); // R6
    if (ctrl.selSlt && opA == opB)
      AST_SLT_EQUAL: assert (result == '0); // R6
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [4:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  aluCtrl_t ctrl;

  alu_ctrl ctrl_i (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA   (opA),
    .opB   (opB),
    .ctrl  (ctrl),
    .result(result)
  );

  assign zero = ~|result;

  always_comb begin
    if (zero)
      AST_ZERO_FLAG: assert ($countones(result) == 0); // R8
    if (ctrl == '0)
      AST_IDLE_RESULT: assert (result == '0); // R7
  end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] wA, wB, wRes;
  logic [4:0]  wOp;
  logic        wZero;
  logic [NW-1:0] nA, nB, nRes;
  logic [4:0]  nOp;
  logic        nZero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_core #(.WIDTH(32)) dut_i (.opA(wA), .opB(wB), .opCode(wOp), .result(wRes), .zero(wZero));
  alu_core #(.WIDTH(NW)) narrow_i (.opA(nA), .opB(nB), .opCode(nOp), .result(nRes), .zero(nZero));

  function automatic string tagOf(logic [4:0] op);
    case (op)
      5'b00000: return "R1";
      5'b00001: return "R2";
      5'b01100: return "R3";
      5'b00010: return "R4";
      5'b00110: return "R5";
      5'b00111: return "R6";
      default:  return "R7";
    endcase
  endfunction

  function automatic longint signedOf(longint v, int w);
    if (v[w-1]) return v - (longint'(1) << w);
    return v;
  endfunction

  function automatic longint model(logic [4:0] op, longint a, longint b, int w);
    longint mask = (longint'(1) << w) - 1;
    case (op)
      5'b00000: return a & b;
      5'b00001: return a | b;
      5'b01100: return ~(a | b) & mask;
      5'b00010: return (a + b) & mask;
      5'b00110: return (a - b) & mask;
      5'b00111: return (signedOf(a, w) < signedOf(b, w)) ? 1 : 0;
      default:  return 0;
    endcase
  endfunction

  task automatic judge(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wide(logic [4:0] op, logic [31:0] a, logic [31:0] b);
    longint exp;
    @(posedge clk);
    wOp = op; wA = a; wB = b;
    @(negedge clk);
    exp = model(op, longint'(a), longint'(b), 32);
    judge(tagOf(op), longint'(wRes), exp);
    judge("R8", longint'(wZero), (exp == 0) ? 1 : 0);
  endtask

  initial begin
    wA = '0; wB = '0; wOp = '0;
    nA = '0; nB = '0; nOp = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial state with all-zero inputs: AND of zeros, flag set (R1, R8)
    judge("R1", longint'(wRes), 0);
    judge("R8", longint'(wZero), 1);

    // R4 full carry ripple, R5 equal operands, R6 overflow boundary, R7 unlisted
    wide(5'b00010, 32'hFFFF_FFFF, 32'h1);
    wide(5'b00010, 32'h7FFF_FFFF, 32'h1);
    wide(5'b00010, 32'h1234_5678, 32'h0FED_CBA9);
    wide(5'b00110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    wide(5'b00110, 32'h0, 32'h1);
    wide(5'b00111, 32'h8000_0000, 32'h7FFF_FFFF);
    wide(5'b00111, 32'h7FFF_FFFF, 32'h8000_0000);
    wide(5'b00111, 32'hFFFF_FFFF, 32'h0);
    wide(5'b00111, 32'h5, 32'h5);
    wide(5'b00000, 32'hF0F0_1234, 32'hFF00_FFFF);
    wide(5'b00001, 32'hF0F0_0000, 32'h0000_1234);
    wide(5'b01100, 32'hF0F0_0000, 32'h0000_1234);
    wide(5'b01100, 32'hFFFF_0000, 32'h0000_FFFF);
    for (int c = 0; c < 32; c++) wide(5'(c), 32'hA5A5_5A5A, 32'h3C3C_C3C3);

    // exhaustive sweep of the narrow instance: R1..R8
    for (int op = 0; op < 32; op++)
      for (int a = 0; a < (1 << NW); a++)
        for (int b = 0; b < (1 << NW); b++) begin
          longint exp;
          @(posedge clk);
          nOp = 5'(op); nA = NW'(a); nB = NW'(b);
          @(negedge clk);
          exp = model(5'(op), longint'(a), longint'(b), NW);
          judge(tagOf(5'(op)), longint'(nRes), exp);
          judge("R8", longint'(nZero), (exp == 0) ? 1 : 0);
        end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule